// File: doc/BRIEF.md
# Packet-Gating Stream FIFO with Error Drop

This block is a store-and-forward buffer between two ready/valid streams. Words enter with a data field, a last marker and a one-bit error sideband. Nothing of a packet becomes visible downstream until the word that closes it has been accepted. At that moment the packet is either committed, if the error bit on its closing word is low, or thrown away as a whole, if that bit is high.

Internally the block keeps three pointers into a single circular store: a read pointer, a speculative write pointer, and a committed write pointer. A good closing word advances the committed pointer to the speculative one. A bad closing word moves the speculative pointer back onto the committed one. The output side only ever sees words between the read pointer and the committed pointer. A packet that is already committed can therefore drain while the next packet is still being written.

The storage holds 2^ADDR_W words. Every packet must fit in it: a packet longer than the store fills it and then holds input ready low until a clear. A synchronous clear empties the buffer in one cycle, and so does the synchronous reset.

Top module: `pkt_gate_fifo`

## Requirements
- R1: While reset is active and in the cycle after it, out_vld is 0 and in_rdy is 1.
- R2: out_vld stays 0 for every word of a packet until that packet's word with in_last=1 has been accepted (in_vld=1 and in_rdy=1 at a clock edge). out_vld is 1 in the cycle after that edge.
- R3: Committed words leave in the order they were accepted, with out_data equal to the accepted in_data. While out_vld=1 and out_rdy=0, out_data and out_last hold steady.
- R4: out_last is 1 exactly on the word that carried in_last=1 at the input, and 0 on every other word.
- R5: If in_err=1 on an accepted word with in_last=1, no word of that packet ever appears at the output. Packets accepted afterwards are delivered as if the dropped one had never arrived.
- R6: When a complete packet is followed by a packet without its last word, the complete packet drains fully. out_vld then stays 0 until the second packet's last word is accepted.
- R7: With ADDR_W=6 the block accepts 64 words in a row with in_rdy=1. in_rdy is 0 while 2^ADDR_W words are held, and returns to 1 once one word has been read.
- R8: A committed packet can be read while a later packet is still being written, so back-to-back packets stream without waiting.
- R9: Asserting clr for one cycle empties the buffer. In the next cycle out_vld=0 and in_rdy=1, and no word, committed or not, from before the clear is ever output.
- R10: A packet longer than 2^ADDR_W words fills the store. After that in_rdy stays 0 and out_vld stays 0 until a clear.
- R11: in_err is sampled only on a word with in_last=1. in_err=1 on any other word has no effect, and the packet is delivered intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of all contents, active high |
| in_data | input | DATA_W | Input word |
| in_vld | input | 1 | Input word valid |
| in_last | input | 1 | Input word closes its packet |
| in_err | input | 1 | Drop this packet; sampled only with in_last |
| in_rdy | output | 1 | Block can accept a word |
| out_data | output | DATA_W | Output word |
| out_vld | output | 1 | Output word valid |
| out_last | output | 1 | Output word closes its packet |
| out_rdy | input | 1 | Downstream takes the output word |

## Verification
The hardest situation to reach from the ports is a store that is full of words that can never be committed. Two states must be told apart here: one where in_rdy is low because a complete packet is waiting to be read, and one where it is low because an oversized packet has filled the store. To reach both, the stimulus first writes a single packet of exactly 2^ADDR_W words with no reads. It then writes a packet that never closes until the store is full, confirms that both handshakes stay low, and recovers only through the clear. Rollback is exercised with dropped packets of one word and of several words placed between good ones. In those packets the error bit is also raised on middle words, where it must be ignored.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  // What an accepted (or absent) input word does to the write side.
  typedef enum logic [1:0] {
    WEV_IDLE   = 2'd0,
    WEV_PUSH   = 2'd1,
    WEV_COMMIT = 2'd2,
    WEV_DROP   = 2'd3
  } wr_ev_e;

  // The error flag only matters on the closing word of a packet.
  function automatic wr_ev_e classify_wr(input logic acc, input logic last, input logic err);
    if (!acc)      return WEV_IDLE;
    else if (!last) return WEV_PUSH;
    else if (err)   return WEV_DROP;
    else            return WEV_COMMIT;
  endfunction

endpackage

// File: rtl/pgf_store.sv
module pgf_store #(
  parameter int WORD_W = 33,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pgf_ptrs.sv
module pgf_ptrs
  import pgf_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PW    = ADDR_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  wr_ev_e        wr_ev,
  input  logic          rd_acc,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] cm_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          avail
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wr_nxt;
  assign wr_nxt = wr_ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      unique case (wr_ev)
        WEV_PUSH:   wr_ptr <= wr_nxt;
        WEV_COMMIT: begin
          wr_ptr <= wr_nxt;
          cm_ptr <= wr_nxt;
        end
        WEV_DROP:   wr_ptr <= cm_ptr;
        default:    ;
      endcase
      if (rd_acc) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  // Full counts uncommitted words too: the write side may not lap the reader.
  assign full  = (wr_ptr - rd_ptr) == PW'(DEPTH);
  assign avail = rd_ptr != cm_ptr;
endmodule

// File: rtl/pkt_gate_fifo.sv
module pkt_gate_fifo
  import pgf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_vld,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld,
  output logic              out_last,
  input  logic              out_rdy
);
  localparam int PW = ADDR_W + 1;

  // Named internal events, also observed by the bound checker.
  logic          wr_acc, rd_acc, full, avail;
  wr_ev_e        wr_ev;
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
  logic [DATA_W:0] rd_word;

  assign in_rdy = ~full;
  assign wr_acc = in_vld & in_rdy;
  assign wr_ev  = classify_wr(wr_acc, in_last, in_err);
  assign rd_acc = avail & out_rdy;

  pgf_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .wr_ev  (wr_ev),
    .rd_acc (rd_acc),
    .wr_ptr (wr_ptr),
    .cm_ptr (cm_ptr),
    .rd_ptr (rd_ptr),
    .full   (full),
    .avail  (avail)
  );

  pgf_store #(.WORD_W(DATA_W + 1), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (wr_ptr[ADDR_W-1:0]),
    .wdata ({in_last, in_data}),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rdata (rd_word)
  );

  assign out_vld  = avail;
  assign out_data = rd_word[DATA_W-1:0];
  assign out_last = rd_word[DATA_W];
endmodule

// File: rtl/pkt_gate_fifo_chk.sv
module pkt_gate_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int PW    = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              in_vld,
  input logic              in_last,
  input logic              in_err,
  input logic              in_rdy,
  input logic [DATA_W-1:0] out_data,
  input logic              out_vld,
  input logic              out_last,
  input logic              out_rdy,
  input logic [PW-1:0]     wr_ptr,
  input logic [PW-1:0]     cm_ptr,
  input logic [PW-1:0]     rd_ptr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic took_good_last, took_bad_last;
  assign took_good_last = in_vld && in_rdy && in_last && !in_err && !clr;
  assign took_bad_last  = in_vld && in_rdy && in_last &&  in_err && !clr;

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && in_rdy)); // R1

  AST_GATE_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(out_vld) |-> $past(took_good_last)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy && !clr) |=> (out_vld && $stable(out_data) && $stable(out_last))); // R3

  AST_DROP_ROLLBACK: assert property (@(posedge clk) disable iff (rst)
    took_bad_last |=> ((wr_ptr == cm_ptr) && $stable(cm_ptr))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    PW'(wr_ptr - rd_ptr) <= PW'(DEPTH)); // R7

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_vld && in_rdy)); // R9

  AST_COMMIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    PW'(cm_ptr - rd_ptr) <= PW'(wr_ptr - rd_ptr)); // R8
endmodule

bind pkt_gate_fifo pkt_gate_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .in_vld   (in_vld),
  .in_last  (in_last),
  .in_err   (in_err),
  .in_rdy   (in_rdy),
  .out_data (out_data),
  .out_vld  (out_vld),
  .out_last (out_last),
  .out_rdy  (out_rdy),
  .wr_ptr   (wr_ptr),
  .cm_ptr   (cm_ptr),
  .rd_ptr   (rd_ptr)
);

// File: tb/tb_pkt_gate_fifo.sv
module tb_pkt_gate_fifo;
  localparam int DW    = 32;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  // Vector: [7:2] packet length, [1] error on last word, [0] error on middle words.
  localparam logic [7:0] PKT_TAB [8] = '{
    {6'd3, 1'b0, 1'b0},
    {6'd1, 1'b0, 1'b0},
    {6'd5, 1'b1, 1'b0},
    {6'd4, 1'b0, 1'b1},
    {6'd2, 1'b1, 1'b1},
    {6'd1, 1'b1, 1'b0},
    {6'd7, 1'b0, 1'b0},
    {6'd2, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst, clr;
  logic [DW-1:0] in_data, out_data;
  logic          in_vld, in_last, in_err, in_rdy;
  logic          out_vld, out_last, out_rdy;

  always #10 clk = ~clk;

  pkt_gate_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .clr(clr),
    .in_data(in_data), .in_vld(in_vld), .in_last(in_last), .in_err(in_err), .in_rdy(in_rdy),
    .out_data(out_data), .out_vld(out_vld), .out_last(out_last), .out_rdy(out_rdy)
  );

  int n_chk = 0;
  int n_bad = 0;
  int seq   = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the word was taken.
  task automatic push(input int d, input bit l, input bit e);
    in_vld = 1'b1; in_data = DW'(d); in_last = l; in_err = e;
    while (!in_rdy) @(negedge clk);
    @(negedge clk);
    in_vld = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic pop(output int d, output bit l);
    out_rdy = 1'b1;
    while (!out_vld) @(negedge clk);
    d = int'(out_data);
    l = out_last;
    @(negedge clk);
    out_rdy = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int d;
    bit l;
    int bad;
    bit rdy_ok;
    int got;
    int got_at_wr_end;

    rst = 1'b1; clr = 1'b0; out_rdy = 1'b0;
    in_vld = 1'b0; in_data = '0; in_last = 1'b0; in_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_vld in reset", out_vld, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_vld after reset", out_vld, 0);
    chk("R1 in_rdy after reset", in_rdy, 1);

    // Table walk: R2, R3, R4, R5, R11
    for (int v = 0; v < 8; v++) begin
      int len;
      bit el, em;
      int base;
      len  = int'(PKT_TAB[v][7:2]);
      el   = PKT_TAB[v][1];
      em   = PKT_TAB[v][0];
      base = seq;
      for (int i = 0; i < len - 1; i++) begin
        push(seq, 1'b0, em);
        seq++;
      end
      chk("R2 no output before last word", out_vld, 0);
      push(seq, 1'b1, el);
      seq++;
      if (el) begin
        chk("R5 dropped packet not output", out_vld, 0);
        chk("R5 space returned after drop", in_rdy, 1);
      end else begin
        chk("R2 output valid after last word", out_vld, 1);
        for (int i = 0; i < len; i++) begin
          pop(d, l);
          chk(em ? "R11 mid-packet error ignored" : "R3 data order", d, base + i);
          chk("R4 last position", l, (i == len - 1) ? 1 : 0);
        end
        chk("R5 nothing extra after drain", out_vld, 0);
      end
    end

    // R6: complete packet followed by a partial one
    for (int i = 0; i < 4; i++) push(100 + i, i == 3, 1'b0);
    for (int i = 0; i < 3; i++) push(200 + i, 1'b0, 1'b0);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      pop(d, l);
      if (d != 100 + i || l != (i == 3)) bad++;
    end
    chk("R6 complete packet drains", bad, 0);
    repeat (3) @(negedge clk);
    chk("R6 partial packet held", out_vld, 0);
    push(203, 1'b1, 1'b0);
    chk("R6 partial released on last", out_vld, 1);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      pop(d, l);
      if (d != 200 + i || l != (i == 3)) bad++;
    end
    chk("R6 second packet content", bad, 0);

    // R8: concurrent write and read of back-to-back packets
    got = 0; got_at_wr_end = 0; bad = 0;
    fork
      begin
        for (int k = 0; k < 6; k++)
          for (int i = 0; i < 5; i++) push(300 + k * 5 + i, i == 4, 1'b0);
        got_at_wr_end = got;
      end
      begin
        for (int n = 0; n < 30; n++) begin
          pop(d, l);
          if (d != 300 + n || l != ((n % 5) == 4)) bad++;
          got++;
        end
      end
    join
    chk("R8 streamed data order", bad, 0);
    chk("R8 reading overlapped writing", got_at_wr_end > 10, 1);

    // R7: exact capacity
    rdy_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (!in_rdy) rdy_ok = 1'b0;
      push(500 + i, i == DEPTH - 1, 1'b0);
    end
    chk("R7 full depth accepted", rdy_ok, 1);
    chk("R7 ready low when full", in_rdy, 0);
    pop(d, l);
    chk("R7 ready back after one read", in_rdy, 1);
    bad = (d != 500) ? 1 : 0;
    for (int i = 1; i < DEPTH; i++) begin
      pop(d, l);
      if (d != 500 + i || l != (i == DEPTH - 1)) bad++;
    end
    chk("R7 full buffer content", bad, 0);

    // R10: oversized packet locks input until clear
    for (int i = 0; i < DEPTH; i++) push(700 + i, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 ready stuck low", in_rdy, 0);
    chk("R10 no output", out_vld, 0);

    // R9: clear empties uncommitted contents
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 out_vld after clear", out_vld, 0);
    chk("R9 in_rdy after clear", in_rdy, 1);

    // R9: clear discards committed contents too
    for (int i = 0; i < 3; i++) push(800 + i, i == 2, 1'b0);
    chk("R9 committed before clear", out_vld, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 committed data discarded", out_vld, 0);
    push(900, 1'b0, 1'b0);
    push(901, 1'b1, 1'b0);
    pop(d, l);
    chk("R9 first word after clear", d, 900);
    pop(d, l);
    chk("R9 second word after clear", d, 901);
    chk("R9 last after clear", l, 1);

    summary();
    $finish;
  end
endmodule